// File: doc/BRIEF.md
# Paged CPU Address Decoder

This block sits between an 8-bit processor with a 16-bit address bus and the memories and peripherals around it. Every cycle in which the processor presents a valid address, the decoder works out which device answers and raises that device's select one clock later. Above 0x9FFF the map is fixed: main program ROM, work RAM, colour RAM, a nibble-wide non-volatile RAM and a handful of write strobes. The lower 40 KB window is redirected at run time by a 4-bit page value that the processor writes into the decoder itself.

Depending on the page, an access to the low window reaches one of five banked ROM slots, is handed to the shared video/DMA bus, or reaches nothing. Reads and writes are routed differently there. The video/DMA bus is granted only while the blitter reports itself idle. A write to the blitter register window starts the blitter and passes on which of its eight registers is addressed. A direction output tells the video bus whether the processor is writing.

Top module: `paged_addr_decoder`

## Requirements
- R1: A synchronous active-high reset clears the page register to 0 and drives every output to 0.
- R2: Outputs appear on the clock edge after the address is sampled. When `addr_valid` is low in the sampled cycle, every select and strobe is 0.
- R3: On reads, `rom_sel` is one-hot. On page 0, bits 0, 1 and 2 cover 0x0000-0x3FFF, 0x4000-0x7FFF and 0x8000-0x9FFF. On page 4, bits 3 and 4 cover 0x0000-0x3FFF and 0x4000-0x7FFF, and 0x8000-0x9FFF selects nothing. Bit 5 covers 0xE000-0xFFFF on any page. Writes never select a ROM.
- R4: `dma_bus_en` rises for an access to 0x0000-0x9FFF when `blit_busy` is low and either the access is a write with page below 8, or it is a read with page 1, 2, 3, 5, 6 or 7.
- R5: A write to 0xCBB0-0xCBBF with `blit_busy` low raises `blit_start` and `dma_bus_en`, and sets `blit_reg` to address bits 2:0. Address bit 3 has no effect on it. Reads of that window, or writes while `blit_busy` is high, raise neither output.
- R6: `nvram_sel` rises for reads of 0xCC00-0xCFFF, and for writes of 0xCD00-0xCFFF while `mem_unprot` is high. On such a write, `nvram_we` is 1 and `nvram_wdata` carries data bits 3:0. Otherwise `nvram_wdata` is 0.
- R7: `dma_write` is 1 only for a write with `blit_busy` low and `wcount_en` high. Otherwise it is 0, which signals a read.
- R8: A write to 0xC800-0xC87F loads data bits 3:0 into the page register. The `page` output shows the new value, and the new value governs the decode of accesses from the next cycle on.
- R9: `work_ram_sel` covers 0xA000-0xBFFF and 0xD000-0xD7FF, and `color_ram_sel` covers 0xC000-0xC7FF, for both directions. 0xD800-0xDFFF selects nothing.
- R10: A write to 0xC880-0xC8FF pulses `led_wr`, and a write to 0xC900-0xC97F pulses `wdog_wr`. Reads of either window pulse neither.
- R11: At most one of the ROM, work RAM, colour RAM and NVRAM selects is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_valid | input | 1 | Processor address and strobe are valid this cycle |
| cpu_addr | input | 16 | Processor address |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_data | input | 8 | Processor write data |
| mem_unprot | input | 1 | High allows NVRAM writes |
| blit_busy | input | 1 | Blitter owns the video bus |
| wcount_en | input | 1 | Write-count enable for the video bus direction |
| page | output | 4 | Current page register |
| rom_sel | output | 6 | One-hot ROM slot select |
| work_ram_sel | output | 1 | Work RAM select |
| color_ram_sel | output | 1 | Colour RAM select |
| nvram_sel | output | 1 | NVRAM select |
| nvram_we | output | 1 | NVRAM write enable |
| nvram_wdata | output | 4 | NVRAM write nibble |
| led_wr | output | 1 | LED latch write strobe |
| wdog_wr | output | 1 | Watchdog kick strobe |
| dma_bus_en | output | 1 | Processor connected to video/DMA bus |
| blit_start | output | 1 | Blitter start strobe |
| blit_reg | output | 3 | Blitter register index |
| dma_write | output | 1 | Video bus direction, 1 = write |

## Verification
Every select, strobe and direction output is due exactly one clock after the cycle in which the address was sampled. A page write shows on `page` at that same edge and steers the decode of the access that follows immediately. The bench drives each access on a falling edge and compares on the next falling edge, one rising edge later. It changes the page in a separate cycle before the access it is meant to steer, so every comparison lands in the single cycle in which its result is due.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  localparam int ROM_SLOTS = 6;

  typedef struct packed {
    logic [ROM_SLOTS-1:0] rom;
    logic                 wram;
    logic                 cram;
    logic                 nvram;
    logic                 nvram_we;
    logic                 led;
    logic                 wdog;
    logic                 grant;
    logic                 start;
    logic                 dma_wr;
    logic [2:0]           breg;
    logic [3:0]           nvdat;
  } dec_t;

  // Banked slots 0..4: page value and 16 KB bank of the low window
  function automatic int slot_page(input int s);
    return (s < 3) ? 0 : 4;
  endfunction

  function automatic int slot_bank(input int s);
    return (s < 3) ? s : s - 3;
  endfunction
endpackage

// File: rtl/page_reg.sv
module page_reg #(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PAGE_W-1:0] din,
  output logic [PAGE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/mem_map.sv
module mem_map #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter int SLOTS  = pdec_pkg::ROM_SLOTS
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [PAGE_W-1:0] page,
  input  logic              unprot,
  output logic [SLOTS-1:0]  rom,
  output logic              wram,
  output logic              cram,
  output logic              nvram,
  output logic              nvram_we,
  output logic              led,
  output logic              wdog,
  output logic              page_ld,
  output logic              low_dma,
  output logic              blit_win
);
  localparam int HI = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] LOW_END = ADDR_W'('hA000);

  logic in_low;
  logic page_hi;
  logic [1:0] bank;

  assign in_low  = addr < LOW_END;
  assign page_hi = page[PAGE_W-1];
  assign bank    = addr[HI -: 2];

  genvar s;
  generate
    for (s = 0; s < SLOTS - 1; s++) begin : g_slot
      assign rom[s] = rd && in_low && (page == PAGE_W'(pdec_pkg::slot_page(s)))
                      && (bank == 2'(pdec_pkg::slot_bank(s)));
    end
  endgenerate
  assign rom[SLOTS-1] = rd && (addr[HI -: 3] == 3'b111);

  always_comb begin
    wram     = (rd || wr) && ((addr[HI -: 3] == 3'b101) || (addr[HI -: 5] == 5'b11010));
    cram     = (rd || wr) && (addr[HI -: 5] == 5'b11000);
    nvram    = 1'b0;
    nvram_we = 1'b0;
    if (addr[HI -: 6] == 6'b110011) begin
      if (rd) nvram = 1'b1;
      if (wr && unprot && (addr[9:8] != 2'b00)) begin
        nvram    = 1'b1;
        nvram_we = 1'b1;
      end
    end
    page_ld  = wr && (addr[HI -: 9] == 9'h190);
    led      = wr && (addr[HI -: 9] == 9'h191);
    wdog     = wr && (addr[HI -: 9] == 9'h192);
    blit_win = (addr[HI -: 12] == 12'hCBB);
    low_dma  = in_low && !page_hi &&
               (wr || (rd && (page[PAGE_W-2:0] != '0) &&
                       (page[PAGE_W-2:0] != (PAGE_W-1)'(4))));
  end
endmodule

// File: rtl/bus_ctrl.sv
module bus_ctrl (
  input  logic low_dma,
  input  logic blit_win,
  input  logic wr,
  input  logic halt,
  input  logic wcnt,
  output logic grant,
  output logic start,
  output logic dma_wr
);
  always_comb begin
    start  = wr && blit_win && !halt;
    grant  = !halt && (low_dma || start);
    dma_wr = wr && !halt && wcnt;
  end
endmodule

// File: rtl/paged_addr_decoder.sv
module paged_addr_decoder #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4,
  parameter int NV_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rnw,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              mem_unprot,
  input  logic              blit_busy,
  input  logic              wcount_en,
  output logic [PAGE_W-1:0] page,
  output logic [5:0]        rom_sel,
  output logic              work_ram_sel,
  output logic              color_ram_sel,
  output logic              nvram_sel,
  output logic              nvram_we,
  output logic [NV_W-1:0]   nvram_wdata,
  output logic              led_wr,
  output logic              wdog_wr,
  output logic              dma_bus_en,
  output logic              blit_start,
  output logic [2:0]        blit_reg,
  output logic              dma_write
);
  import pdec_pkg::*;

  logic rd, wr;
  logic page_ld, low_dma, blit_win;
  dec_t nxt, cur;

  assign rd = addr_valid && cpu_rnw;
  assign wr = addr_valid && !cpu_rnw;

  page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk (clk), .rst (rst), .load (page_ld),
    .din (cpu_data[PAGE_W-1:0]), .q (page)
  );

  mem_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SLOTS(ROM_SLOTS)) u_map (
    .addr (cpu_addr), .rd (rd), .wr (wr), .page (page), .unprot (mem_unprot),
    .rom (nxt.rom), .wram (nxt.wram), .cram (nxt.cram), .nvram (nxt.nvram),
    .nvram_we (nxt.nvram_we), .led (nxt.led), .wdog (nxt.wdog),
    .page_ld (page_ld), .low_dma (low_dma), .blit_win (blit_win)
  );

  bus_ctrl u_bus (
    .low_dma (low_dma), .blit_win (blit_win), .wr (wr), .halt (blit_busy),
    .wcnt (wcount_en), .grant (nxt.grant), .start (nxt.start), .dma_wr (nxt.dma_wr)
  );

  assign nxt.breg  = nxt.start ? cpu_addr[2:0] : 3'd0;
  assign nxt.nvdat = nxt.nvram_we ? cpu_data[NV_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else     cur <= nxt;
  end

  assign rom_sel       = cur.rom;
  assign work_ram_sel  = cur.wram;
  assign color_ram_sel = cur.cram;
  assign nvram_sel     = cur.nvram;
  assign nvram_we      = cur.nvram_we;
  assign nvram_wdata   = cur.nvdat;
  assign led_wr        = cur.led;
  assign wdog_wr       = cur.wdog;
  assign dma_bus_en    = cur.grant;
  assign blit_start    = cur.start;
  assign blit_reg      = cur.breg;
  assign dma_write     = cur.dma_wr;

  // R4: no bus grant while the blitter was busy
  assert_grant_idle_R4: assert property (@(posedge clk) disable iff (rst)
    $past(blit_busy) |-> !dma_bus_en);

  // R5: a start strobe always comes with the bus grant
  assert_start_grant_R5: assert property (@(posedge clk) disable iff (rst)
    blit_start |-> dma_bus_en);

  // R6: NVRAM writes only when unprotected and the access was a write
  assert_nvram_prot_R6: assert property (@(posedge clk) disable iff (rst)
    nvram_we |-> ($past(mem_unprot) && !$past(cpu_rnw)));

  // R7: write direction only for an idle-blitter write
  assert_dir_write_R7: assert property (@(posedge clk) disable iff (rst)
    dma_write |-> ($past(addr_valid) && !$past(cpu_rnw) && !$past(blit_busy)));

  // R8: page window write loads the low data bits
  assert_page_load_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(addr_valid) && !$past(cpu_rnw) && !$past(rst) &&
     ($past(cpu_addr[ADDR_W-1 -: 9]) == 9'h190))
    |-> (page == $past(cpu_data[PAGE_W-1:0])));

  // R2: an idle cycle leaves no memory select behind
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(addr_valid) && !$past(rst)) |-> (rom_sel == '0 && !nvram_sel && !dma_bus_en));

  // R11: memory selects are mutually exclusive
  assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_sel, work_ram_sel, color_ram_sel, nvram_sel}));
endmodule

// File: tb/paged_addr_decoder_test.sv
`timescale 1ns/1ps
module paged_addr_decoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_valid = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic cpu_rnw = 1'b1;
  logic [7:0] cpu_data = '0;
  logic mem_unprot = 1'b0;
  logic blit_busy = 1'b0;
  logic wcount_en = 1'b1;
  logic [3:0] page;
  logic [5:0] rom_sel;
  logic work_ram_sel, color_ram_sel, nvram_sel, nvram_we;
  logic [3:0] nvram_wdata;
  logic led_wr, wdog_wr, dma_bus_en, blit_start, dma_write;
  logic [2:0] blit_reg;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  paged_addr_decoder uut (
    .clk(clk), .rst(rst), .addr_valid(addr_valid), .cpu_addr(cpu_addr),
    .cpu_rnw(cpu_rnw), .cpu_data(cpu_data), .mem_unprot(mem_unprot),
    .blit_busy(blit_busy), .wcount_en(wcount_en), .page(page), .rom_sel(rom_sel),
    .work_ram_sel(work_ram_sel), .color_ram_sel(color_ram_sel), .nvram_sel(nvram_sel),
    .nvram_we(nvram_we), .nvram_wdata(nvram_wdata), .led_wr(led_wr), .wdog_wr(wdog_wr),
    .dma_bus_en(dma_bus_en), .blit_start(blit_start), .blit_reg(blit_reg),
    .dma_write(dma_write)
  );

  typedef struct packed {
    logic [3:0]  pg;
    logic [15:0] a;
    logic        rd;
    logic        hlt;
    logic        unp;
    logic [5:0]  rom;
    logic        wram;
    logic        cram;
    logic        nv;
    logic        nvwe;
    logic        grant;
    logic        start;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 16'h0010, 1'b1, 1'b0, 1'b0, 6'b000001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd0, 16'h5000, 1'b1, 1'b0, 1'b0, 6'b000010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd0, 16'h9000, 1'b1, 1'b0, 1'b0, 6'b000100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd4, 16'h1000, 1'b1, 1'b0, 1'b0, 6'b001000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd4, 16'h6000, 1'b1, 1'b0, 1'b0, 6'b010000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd4, 16'h9000, 1'b1, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd0, 16'hF000, 1'b1, 1'b0, 1'b0, 6'b100000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd2, 16'h1000, 1'b1, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4
    '{4'd2, 16'h1000, 1'b1, 1'b1, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
    '{4'd0, 16'h1000, 1'b0, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4
    '{4'd8, 16'h1000, 1'b0, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
    '{4'd8, 16'h1000, 1'b1, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
    '{4'd1, 16'h2000, 1'b1, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4
    '{4'd0, 16'hCBB8, 1'b0, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R5
    '{4'd0, 16'hCBB3, 1'b0, 1'b1, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5
    '{4'd0, 16'hCBB0, 1'b1, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5
    '{4'd0, 16'hCC00, 1'b1, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R6
    '{4'd0, 16'hCC80, 1'b0, 1'b0, 1'b1, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{4'd0, 16'hCD00, 1'b0, 1'b0, 1'b1, 6'b000000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R6
    '{4'd0, 16'hCFFF, 1'b0, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{4'd0, 16'hA000, 1'b1, 1'b0, 1'b0, 6'b000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
    '{4'd0, 16'hD7FF, 1'b0, 1'b0, 1'b0, 6'b000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
    '{4'd0, 16'hD800, 1'b1, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
    '{4'd0, 16'hC7FF, 1'b0, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
    '{4'd0, 16'hC800, 1'b1, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R8
    '{4'd0, 16'hE000, 1'b0, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd7, 16'h9FFF, 1'b1, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4
    '{4'd4, 16'h0000, 1'b0, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}  // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One access: drive at a falling edge, result due one rising edge later
  task automatic access(input logic [15:0] a, input logic rd, input logic [7:0] d);
    @(negedge clk);
    addr_valid = 1'b1; cpu_addr = a; cpu_rnw = rd; cpu_data = d;
    @(negedge clk);
    addr_valid = 1'b0; cpu_rnw = 1'b1;
  endtask

  task automatic set_page(input logic [3:0] p);
    logic h;
    h = blit_busy;
    blit_busy = 1'b0;
    access(16'hC800, 1'b0, {4'h0, p});
    blit_busy = h;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 page", 32'(page), 0);
    check("R1 selects", 32'({rom_sel, work_ram_sel, color_ram_sel, nvram_sel, dma_bus_en,
                             blit_start, dma_write, led_wr, wdog_wr}), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      set_page(v.pg);
      blit_busy = v.hlt; mem_unprot = v.unp;
      access(v.a, v.rd, 8'h00);
      check($sformatf("vec %0d R3 rom_sel", i), 32'(rom_sel), 32'(v.rom));
      check($sformatf("vec %0d R9 ram", i), 32'({work_ram_sel, color_ram_sel}),
            32'({v.wram, v.cram}));
      check($sformatf("vec %0d R6 nvram", i), 32'({nvram_sel, nvram_we}), 32'({v.nv, v.nvwe}));
      check($sformatf("vec %0d R4 grant", i), 32'(dma_bus_en), 32'(v.grant));
      check($sformatf("vec %0d R5 start", i), 32'(blit_start), 32'(v.start));
      blit_busy = 1'b0; mem_unprot = 1'b0;
    end

    // R8: page readback and effect on the very next access
    set_page(4'd4);
    check("R8 page out", 32'(page), 4);
    access(16'h1000, 1'b1, 8'h00);
    check("R8 next access uses page 4", 32'(rom_sel), 32'h08);
    access(16'hC810, 1'b0, 8'hF2);
    check("R8 low nibble only", 32'(page), 2);

    // R2: idle cycle deasserts everything
    @(negedge clk);
    addr_valid = 1'b0; cpu_addr = 16'hF000; cpu_rnw = 1'b1;
    @(negedge clk);
    check("R2 idle", 32'({rom_sel, nvram_sel, dma_bus_en, work_ram_sel}), 0);

    // R5: bit 3 ignored in register index
    set_page(4'd0);
    access(16'hCBB8, 1'b0, 8'h00);
    check("R5 reg at B8", 32'(blit_reg), 0);
    access(16'hCBBD, 1'b0, 8'h00);
    check("R5 reg at BD", 32'(blit_reg), 5);
    access(16'hCBB5, 1'b0, 8'h00);
    check("R5 reg at B5", 32'(blit_reg), 5);

    // R6: nibble passes through on an unprotected write
    mem_unprot = 1'b1;
    access(16'hCD10, 1'b0, 8'hA7);
    check("R6 wdata", 32'(nvram_wdata), 7);
    access(16'hCD10, 1'b1, 8'hA7);
    check("R6 wdata on read", 32'(nvram_wdata), 0);
    mem_unprot = 1'b0;

    // R7: direction output
    wcount_en = 1'b1;
    access(16'h2000, 1'b0, 8'h00);
    check("R7 write", 32'(dma_write), 1);
    wcount_en = 1'b0;
    access(16'h2000, 1'b0, 8'h00);
    check("R7 no wcount", 32'(dma_write), 0);
    wcount_en = 1'b1; blit_busy = 1'b1;
    access(16'h2000, 1'b0, 8'h00);
    check("R7 busy", 32'(dma_write), 0);
    blit_busy = 1'b0;
    access(16'h2000, 1'b1, 8'h00);
    check("R7 read", 32'(dma_write), 0);

    // R10: LED and watchdog strobes
    access(16'hC8C0, 1'b0, 8'h00);
    check("R10 led", 32'({led_wr, wdog_wr}), 32'b10);
    access(16'hC97F, 1'b0, 8'h00);
    check("R10 wdog", 32'({led_wr, wdog_wr}), 32'b01);
    access(16'hC900, 1'b1, 8'h00);
    check("R10 read no strobe", 32'({led_wr, wdog_wr}), 0);
    check("R10 page untouched", 32'(page), 0);

    // R1: reset after activity
    set_page(4'd2);
    @(negedge clk);
    addr_valid = 1'b1; cpu_addr = 16'h1000; cpu_rnw = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R1 page after reset", 32'(page), 0);
    check("R1 grant after reset", 32'(dma_bus_en), 0);
    rst = 1'b0; addr_valid = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule